// File: doc/BRIEF.md
# Sign-Magnitude Extended Integer Divider

This block is a sequential integer divider for a compact-instruction datapath. It divides a signed dividend of twice the selected operand width by a signed divisor of one operand width. It returns a quotient of twice the operand width and a remainder of one operand width. The operand width is chosen for each operation from four sizes: 8, 16, 32 or 64 bits.

The divider first works on the magnitudes of both operands. It then gives the quotient and the remainder one common sign, chosen by whether the operand signs agree. As a result, the remainder follows the sign of the quotient and not the sign of the dividend. Results narrower than their port are sign-extended. Placing the results into the register file is the job of the surrounding datapath.

Control is a plain start/busy/done handshake, with no back-pressure. A start is taken only while the divider is idle. The results and the divide-by-zero flag are valid while done is high, and they stay unchanged until the next start is accepted.

Top module: `sm_xdiv`

## Requirements
- R1: The size code selects the operand width N: 0 selects 8, 1 selects 16, 2 selects 32 and 3 selects 64. Only the low 2N bits of the dividend and the low N bits of the divisor are used, each read as two's complement. Any bits above them have no effect on the results.
- R2: A start is accepted on a rising edge where start is high and busy is low. For a nonzero divisor, busy is high for exactly 2N cycles beginning in the cycle after acceptance. In the cycle after the last busy cycle, done is high for one cycle and busy is low.
- R3: A start raised while busy is high is ignored. The operation in flight keeps its timing and its results.
- R4: The quotient magnitude is floor(|dividend| / |divisor|). The remainder magnitude is |dividend| minus the quotient magnitude times |divisor|.
- R5: When the operands have the same sign, the quotient and the remainder are both zero or positive. When the signs differ, both are the negated magnitudes, so each is zero or negative.
- R6: The quotient is the low 2N bits of the signed result, sign-extended to 128 bits. The one case that wraps is the most negative dividend divided by -1. The remainder is an N-bit value sign-extended to 64 bits.
- R7: A divisor whose low N bits are all zero is flagged as divide-by-zero. Done goes high in the cycle after acceptance, busy stays low, div_zero is 1, and the quotient and remainder are zero.
- R8: The quotient, the remainder and div_zero hold their values from done until the next accepted start.
- R9: While reset is asserted, and after it, busy, done and div_zero are 0 and the quotient and remainder are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin an operation when idle |
| size | input | 2 | Operand width code |
| dividend | input | 128 | Double-width signed dividend |
| divisor | input | 64 | Single-width signed divisor |
| busy | output | 1 | Division in progress |
| done | output | 1 | One-cycle completion pulse |
| div_zero | output | 1 | Divisor was zero |
| quotient | output | 128 | Signed quotient, sign-extended |
| remainder | output | 64 | Signed remainder, sign-extended |

## Verification
A wrong iteration count, or a busy flag that drops early, shows up as busy or done being wrong in the very cycle it happens. The reference compares both of these every clock.

A wrong partial remainder, or a wrong shifted quotient bit, stays hidden until done. At that point it shows as a wrong quotient or remainder magnitude.

A sign or size register latched incorrectly at acceptance shows at done as a flipped sign or a wrong sign extension. A result register overwritten while idle breaks the hold check in the next idle cycle.

// File: rtl/smxd_pkg.sv
package smxd_pkg;
  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_LONG = 2'd3
  } sz_e;

  // operand width in bits for a size code, given the register width
  function automatic int unsigned op_bits(input int unsigned xlen, input logic [1:0] code);
    return xlen >> (3 - int'(code));
  endfunction
endpackage

// File: rtl/smxd_prep.sv
module smxd_prep #(
  parameter int XLEN = 64
) (
  input  logic [1:0]        size,
  input  logic [2*XLEN-1:0] dvd,
  input  logic [XLEN-1:0]   dvs,
  output logic [2*XLEN-1:0] dvd_mag,
  output logic [XLEN-1:0]   dvs_mag,
  output logic              neg,
  output logic              dvs_zero
);
  localparam int DLEN = 2 * XLEN;

  int unsigned             opw;
  logic signed [DLEN-1:0]  dsx;
  logic signed [XLEN-1:0]  vsx;

  // trim each operand to its selected width, sign-extend, take magnitude
  always_comb begin
    opw      = smxd_pkg::op_bits(XLEN, size);
    dsx      = $signed(dvd << (DLEN - 2 * opw));
    dsx      = dsx >>> (DLEN - 2 * opw);
    vsx      = $signed(dvs << (XLEN - opw));
    vsx      = vsx >>> (XLEN - opw);
    dvd_mag  = dsx[DLEN-1] ? DLEN'(-dsx) : DLEN'(dsx);
    dvs_mag  = vsx[XLEN-1] ? XLEN'(-vsx) : XLEN'(vsx);
    neg      = dsx[DLEN-1] ^ vsx[XLEN-1];
    dvs_zero = (vsx == '0);
  end
endmodule

// File: rtl/smxd_core.sv
module smxd_core #(
  parameter int XLEN = 64,
  parameter int CW   = $clog2(2 * XLEN + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              clr,
  input  logic [CW-1:0]     iters,
  input  logic [2*XLEN-1:0] dvd_mag,
  input  logic [XLEN-1:0]   dvs_mag,
  output logic              busy,
  output logic              done,
  output logic [2*XLEN-1:0] q,
  output logic [XLEN-1:0]   r
);
  localparam int DLEN = 2 * XLEN;
  localparam logic [CW-1:0] DLEN_C = CW'(DLEN);

  logic [CW-1:0]   cnt;
  logic [XLEN-1:0] dvs_r;
  logic [XLEN:0]   shifted;
  logic [XLEN:0]   diff;
  logic            ge;

  // one restoring step: bring in the next dividend bit, trial-subtract
  always_comb begin
    shifted = {r, q[DLEN-1]};
    diff    = shifted - {1'b0, dvs_r};
    ge      = shifted >= {1'b0, dvs_r};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy  <= 1'b0;
      done  <= 1'b0;
      cnt   <= '0;
      q     <= '0;
      r     <= '0;
      dvs_r <= '0;
    end else begin
      done <= 1'b0;
      if (clr) begin
        q    <= '0;
        r    <= '0;
        done <= 1'b1;
      end else if (load) begin
        // left-align the magnitude so its top bit is consumed first
        q     <= dvd_mag << (DLEN_C - iters);
        r     <= '0;
        dvs_r <= dvs_mag;
        cnt   <= iters;
        busy  <= 1'b1;
      end else if (busy) begin
        q   <= {q[DLEN-2:0], ge};
        r   <= ge ? diff[XLEN-1:0] : shifted[XLEN-1:0];
        cnt <= cnt - 1'b1;
        if (cnt == CW'(1)) begin
          busy <= 1'b0;
          done <= 1'b1;
        end
      end
    end
  end

  AST_RUN_CONTINUES: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && cnt != CW'(1) && !clr) |=> busy); // R2
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy); // R2
  AST_LOAD_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (load || clr) |-> !busy); // R3
  AST_PARTIAL_BELOW_DIVISOR: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (r < dvs_r)); // R4
endmodule

// File: rtl/smxd_fix.sv
module smxd_fix #(
  parameter int XLEN = 64
) (
  input  logic [1:0]        size,
  input  logic              neg,
  input  logic [2*XLEN-1:0] q_mag,
  input  logic [XLEN-1:0]   r_mag,
  output logic [2*XLEN-1:0] quot,
  output logic [XLEN-1:0]   rem
);
  localparam int DLEN = 2 * XLEN;

  int unsigned            opw;
  logic [DLEN-1:0]        qs;
  logic [XLEN-1:0]        rs;
  logic signed [DLEN-1:0] qx;
  logic signed [XLEN-1:0] rx;

  // apply the common sign, then sign-extend from the selected width
  always_comb begin
    opw  = smxd_pkg::op_bits(XLEN, size);
    qs   = neg ? -q_mag : q_mag;
    rs   = neg ? -r_mag : r_mag;
    qx   = $signed(qs << (DLEN - 2 * opw));
    qx   = qx >>> (DLEN - 2 * opw);
    rx   = $signed(rs << (XLEN - opw));
    rx   = rx >>> (XLEN - opw);
    quot = qx;
    rem  = rx;
  end
endmodule

// File: rtl/sm_xdiv.sv
module sm_xdiv #(
  parameter int XLEN = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [1:0]        size,
  input  logic [2*XLEN-1:0] dividend,
  input  logic [XLEN-1:0]   divisor,
  output logic              busy,
  output logic              done,
  output logic              div_zero,
  output logic [2*XLEN-1:0] quotient,
  output logic [XLEN-1:0]   remainder
);
  localparam int DLEN = 2 * XLEN;
  localparam int CW   = $clog2(DLEN + 1);

  logic              acc;
  logic              neg_now, zero_now;
  logic [DLEN-1:0]   dvd_mag, q_mag;
  logic [XLEN-1:0]   dvs_mag, r_mag;
  logic [CW-1:0]     iters;
  smxd_pkg::sz_e     size_q;
  logic              neg_q;

  assign acc   = start && !busy;
  assign iters = CW'(2 * smxd_pkg::op_bits(XLEN, size));

  smxd_prep #(.XLEN(XLEN)) u_prep (
    .size(size), .dvd(dividend), .dvs(divisor),
    .dvd_mag(dvd_mag), .dvs_mag(dvs_mag), .neg(neg_now), .dvs_zero(zero_now)
  );

  smxd_core #(.XLEN(XLEN), .CW(CW)) u_core (
    .clk(clk), .rst_n(rst_n),
    .load(acc && !zero_now), .clr(acc && zero_now), .iters(iters),
    .dvd_mag(dvd_mag), .dvs_mag(dvs_mag),
    .busy(busy), .done(done), .q(q_mag), .r(r_mag)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      size_q   <= smxd_pkg::SZ_BYTE;
      neg_q    <= 1'b0;
      div_zero <= 1'b0;
    end else if (acc) begin
      size_q   <= smxd_pkg::sz_e'(size);
      neg_q    <= neg_now && !zero_now;
      div_zero <= zero_now;
    end
  end

  smxd_fix #(.XLEN(XLEN)) u_fix (
    .size(size_q), .neg(neg_q), .q_mag(q_mag), .r_mag(r_mag),
    .quot(quotient), .rem(remainder)
  );

  AST_ZERO_DIVISOR_RESULTS: assert property (@(posedge clk) disable iff (!rst_n)
    (done && div_zero) |-> (quotient == '0 && remainder == '0)); // R7
  AST_COMMON_SIGN: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !div_zero && quotient != '0 && remainder != '0)
      |-> (quotient[DLEN-1] == remainder[XLEN-1])); // R5
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !acc) |=> ($stable(quotient) && $stable(remainder) && $stable(div_zero))); // R8
  AST_ZERO_NO_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && zero_now) |=> (!busy && done)); // R7
endmodule

// File: tb/sm_xdiv_bench.sv
module sm_xdiv_bench;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         start = 1'b0;
  logic [1:0]   size = 2'd0;
  logic [127:0] dividend = '0;
  logic [63:0]  divisor = '0;
  logic         busy, done, div_zero;
  logic [127:0] quotient;
  logic [63:0]  remainder;

  int vecs = 0;
  int errs = 0;

  // reference state
  bit           m_busy = 0, m_done = 0, m_dz = 0;
  int           m_cnt = 0;
  logic [127:0] m_q = '0, p_q = '0;
  logic [63:0]  m_r = '0, p_r = '0;

  always #10ns clk = ~clk;

  sm_xdiv u_sm_xdiv (
    .clk(clk), .rst_n(rst_n), .start(start), .size(size),
    .dividend(dividend), .divisor(divisor),
    .busy(busy), .done(done), .div_zero(div_zero),
    .quotient(quotient), .remainder(remainder)
  );

  function automatic void ref_div(input int n, input logic [127:0] a, input logic [63:0] b,
                                  output logic [127:0] q, output logic [63:0] r, output bit z);
    int sha = 128 - 2 * n;
    int shb = 128 - n;
    logic signed [127:0] sa, sb, t;
    logic [127:0] ma, mb, mq, mr;
    sa = $signed(a << sha);
    sa = sa >>> sha;
    sb = $signed({64'd0, b} << shb);
    sb = sb >>> shb;
    z  = (sb == 0);
    q  = '0;
    r  = '0;
    if (!z) begin
      ma = sa[127] ? -sa : sa;
      mb = sb[127] ? -sb : sb;
      mq = ma / mb;
      mr = ma % mb;
      if (sa[127] != sb[127]) begin
        mq = -mq;
        mr = -mr;
      end
      t = $signed(mq << sha);
      q = t >>> sha;
      t = $signed(mr << shb);
      t = t >>> shb;
      r = t[63:0];
    end
  endfunction

  task automatic compare(input string tag);
    vecs++;
    if (busy !== m_busy) begin
      errs++;
      $display("FAIL R2 (%s) busy got %0b exp %0b", tag, busy, m_busy);
    end
    if (done !== m_done) begin
      errs++;
      $display("FAIL R2 (%s) done got %0b exp %0b", tag, done, m_done);
    end
    if (!m_busy) begin
      if (quotient !== m_q) begin
        errs++;
        $display("FAIL %s quotient got %h exp %h", tag, quotient, m_q);
      end
      if (remainder !== m_r) begin
        errs++;
        $display("FAIL %s remainder got %h exp %h", tag, remainder, m_r);
      end
      if (div_zero !== m_dz) begin
        errs++;
        $display("FAIL %s div_zero got %0b exp %0b", tag, div_zero, m_dz);
      end
    end
  endtask

  // one clock: check outputs, drive inputs, advance the reference
  task automatic cyc(input bit st, input logic [1:0] sz, input logic [127:0] a,
                     input logic [63:0] b, input string tag);
    logic [127:0] q;
    logic [63:0]  r;
    bit           z;
    @(negedge clk);
    compare(tag);
    start    = st;
    size     = sz;
    dividend = a;
    divisor  = b;
    if (st && !m_busy) begin
      ref_div(8 << sz, a, b, q, r, z);
      if (z) begin
        m_done = 1; m_dz = 1; m_q = '0; m_r = '0;
      end else begin
        m_busy = 1; m_done = 0; m_dz = 0; m_cnt = 2 * (8 << sz);
        p_q = q; p_r = r;
      end
    end else if (m_busy) begin
      m_cnt--;
      if (m_cnt == 0) begin
        m_busy = 0; m_done = 1; m_q = p_q; m_r = p_r;
      end
    end else begin
      m_done = 0;
    end
    @(posedge clk);
  endtask

  // full operation; noisy raises start with other operands while busy
  task automatic run_op(input logic [1:0] sz, input logic [127:0] a, input logic [63:0] b,
                        input string tag, input bit noisy);
    cyc(1, sz, a, b, tag);
    while (m_busy) cyc(noisy, ~sz, ~a, ~b, noisy ? "R3" : tag);
    cyc(0, sz, a, b, tag);
    cyc(0, sz, ~a, b, "R8");
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errs++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    compare("R9");
    @(negedge clk);
    rst_n = 1'b1;
    cyc(0, 0, '0, '0, "R9");
    // R4 R5 basic signs, byte size
    run_op(0, 128'd100, 64'd7, "R4", 0);
    run_op(0, 128'hFF9C, 64'd7, "R5", 0);        // -100 / 7
    run_op(0, 128'd100, 64'hF9, "R5", 0);        // 100 / -7
    run_op(0, 128'hFF9C, 64'hF9, "R5", 0);       // -100 / -7
    // R1 upper bits ignored
    run_op(0, {112'hABCD_1234_5678, 16'h0123}, {56'hDEAD_BEEF_CAFE_77, 8'h05}, "R1", 0);
    run_op(1, {96'h1, 32'h8000_0001}, 64'hFFFF_FFFF_FFFF_0003, "R1", 0);
    // R6 wrap and sign extension
    run_op(0, 128'h8000, 64'hFF, "R6", 0);
    run_op(2, 128'hFFFF_FFFF_FFFF_FFFF, 64'd3, "R6", 0);
    run_op(3, {1'b1, 127'd0}, 64'hFFFF_FFFF_FFFF_FFFF, "R6", 0);
    run_op(3, {64'h0000_0000_0000_0001, 64'h0}, 64'h8000_0000_0000_0000, "R6", 0);
    // R7 zero divisor at each size, including upper garbage
    run_op(0, 128'd55, 64'hFF00, "R7", 0);
    run_op(1, 128'd55, '0, "R7", 0);
    run_op(3, 128'd55, '0, "R7", 0);
    cyc(1, 2, 128'd9, 64'h1_0000_0000, "R7");
    cyc(1, 2, 128'd9, 64'd4, "R7");               // back-to-back accept right after done
    while (m_busy) cyc(0, 2, '0, '0, "R2");
    cyc(0, 2, '0, '0, "R2");
    // R3 start during busy
    run_op(1, 128'd12345, 64'd17, "R3", 1);
    run_op(3, 128'h1234_5678_9ABC_DEF0_0FED_CBA9_8765_4321, 64'hFFFF_FFFF_FFFF_FFF1, "R3", 1);
    for (int i = 0; i < 40; i++) begin
      logic [127:0] a;
      logic [63:0]  b;
      a = {$urandom, $urandom, $urandom, $urandom};
      b = {$urandom, $urandom};
      if (i % 4 == 1) b = b >> ($urandom % 60);
      run_op(2'($urandom % 4), a, b, "R4", i % 5 == 0);
    end
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end
endmodule